// File: doc/BRIEF.md
# Issue Interlock with Class-Dependent Stall Gaps

This block sits at the issue stage of a single-issue, in-order pipeline that forwards results between stages. Every cycle it may be offered one decoded instruction. The instruction carries a class code, an optional destination register and up to two optional source registers. Each register is named by a file flag (integer or floating-point) and an index. The block remembers how recently each register's pending producer issued. It holds the offered instruction until every operand it reads is far enough from its producer. The required distance depends on both the producer class and the consumer class.

The instruction arrives on a valid/ready stream. The producer side asserts `in_valid` with a packet and must hold the whole packet steady until the cycle in which `in_ready` is high. `in_ready` falls only when the offered packet has an unresolved dependency. The block never stalls an empty slot. The cycle in which valid and ready are both high is the issue cycle, and `issue` marks it. `stall` marks the cycles in which a valid packet is held back.

A conditional branch has one delay slot. The next instruction to issue after the branch is flagged on `delay_slot` and is never cancelled.

Top module: `issue_interlock`

## Requirements
- R1: `in_cls` is encoded as 0 other, 1 load, 2 FP add, 3 integer add, 4 store, 5 conditional branch. A register operand is a file flag (1 = floating-point, 0 = integer) plus a 5-bit index. `issue` = `in_valid` & `in_ready` and `stall` = `in_valid` & !`in_ready`. With `in_valid` low, `in_ready` is high and both `stall` and `issue` are low.
- R2: An instruction reading a register written by a load issues no earlier than the fourth cycle after the load issued, which is 3 stall cycles when it directly follows.
- R3: An instruction other than a store that reads an FP add result waits 5 stall cycles after the FP add when it directly follows.
- R4: A store that reads an FP add result waits 4 stall cycles when it directly follows.
- R5: A conditional branch that reads an integer add result waits 2 stall cycles when it directly follows.
- R6: Any non-branch instruction that reads an integer add result waits 1 stall cycle when it directly follows.
- R7: A gap is counted from the producer's issue cycle, so instructions issued in between shorten the stall and a held instruction's remaining stall shrinks every cycle. With two sources the larger of the two stalls applies, and an instruction with no pending dependency issues in the cycle it is offered.
- R8: Integer and floating-point registers with the same index are independent. Only a match in both file flag and index forms a dependency.
- R9: Integer register 0 is never a dependency, whether written or read.
- R10: The instruction that issues next after a conditional branch has `delay_slot` high in its issue cycle. Its stalls follow the same gap rules as any other instruction. `delay_slot` is low for every other issue.
- R11: A synchronous reset clears all pending producers and the pending delay slot. After reset no instruction is stalled and the next issue is not flagged as a delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A decoded instruction is offered |
| in_ready | output | 1 | Offered instruction may issue this cycle |
| in_cls | input | 3 | Instruction class code |
| in_dst_vld | input | 1 | Instruction writes a destination register |
| in_dst_fp | input | 1 | Destination is in the FP file |
| in_dst_idx | input | 5 | Destination register index |
| in_sa_vld | input | 1 | First source operand is used |
| in_sa_fp | input | 1 | First source is in the FP file |
| in_sa_idx | input | 5 | First source register index |
| in_sb_vld | input | 1 | Second source operand is used |
| in_sb_fp | input | 1 | Second source is in the FP file |
| in_sb_idx | input | 5 | Second source register index |
| stall | output | 1 | Offered instruction is held this cycle |
| issue | output | 1 | Offered instruction issues this cycle |
| delay_slot | output | 1 | Issuing instruction occupies a branch delay slot |

## Verification
The main stream is an unrolled vector-add loop: two loads, an FP add, a store, two integer adds and a branch with its slot. This separates the load gap, the store-specific FP gap and the branch-specific integer gap within one realistic sequence. Further patterns place fillers between producer and consumer to show that the countdown runs from the producer's issue. They read the same index from the other file to separate the two namespaces, read and write integer register 0, and give a consumer two producers of different age so that only the larger stall applies. Directed cases apply reset during a stall and after a branch, and offer a dependent packet with `in_valid` low.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CLS_OTHER  = 3'd0,
    CLS_LOAD   = 3'd1,
    CLS_FPADD  = 3'd2,
    CLS_INTADD = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_BRANCH = 3'd5
  } cls_e;

  typedef enum logic [1:0] {
    PK_NONE   = 2'd0,
    PK_LOAD   = 2'd1,
    PK_FPADD  = 2'd2,
    PK_INTADD = 2'd3
  } pk_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ilk_sb_file.sv
module ilk_sb_file
  import ilk_pkg::*;
#(
  parameter int NREG = 32,
  parameter int CNTW = 3,
  parameter bit SKIP_ZERO = 1'b0,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [CNTW-1:0] wr_cnt,
  input  pk_e             wr_kind,
  input  logic [IDXW-1:0] rd_idx_a,
  input  logic [IDXW-1:0] rd_idx_b,
  output logic [CNTW-1:0] cnt_a,
  output pk_e             kind_a,
  output logic [CNTW-1:0] cnt_b,
  output pk_e             kind_b
);

  localparam logic [CNTW-1:0] ONE = CNTW'(1);

  logic [CNTW-1:0] cnt_q  [NREG];
  pk_e             kind_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (SKIP_ZERO && i == 0) begin : g_hard_zero
      assign cnt_q[i]  = '0;
      assign kind_q[i] = PK_NONE;
    end else begin : g_live
      logic hit;
      assign hit = wr_en && (wr_idx == IDXW'(i));

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q[i]  <= '0;
          kind_q[i] <= PK_NONE;
        end else if (hit) begin
          cnt_q[i]  <= wr_cnt;
          kind_q[i] <= wr_kind;
        end else if (cnt_q[i] != '0) begin
          cnt_q[i]  <= cnt_q[i] - ONE;
        end
      end

      // R7
      cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit && cnt_q[i] != '0) |=> (cnt_q[i] == $past(cnt_q[i]) - ONE));
    end
  end

  assign cnt_a  = cnt_q[rd_idx_a];
  assign kind_a = kind_q[rd_idx_a];
  assign cnt_b  = cnt_q[rd_idx_b];
  assign kind_b = kind_q[rd_idx_b];

endmodule

// File: rtl/ilk_src_need.sv
module ilk_src_need
  import ilk_pkg::*;
#(
  parameter int CNTW       = 3,
  parameter int LD_GAP     = 3,
  parameter int FPA_GAP    = 5,
  parameter int FPA_ST_GAP = 4,
  parameter int INT_BR_GAP = 2,
  parameter int INT_GAP    = 1
) (
  input  logic            src_vld,
  input  logic [CNTW-1:0] cnt,
  input  pk_e             kind,
  input  cls_e            cons,
  output logic [CNTW-1:0] need
);

  localparam int FPA_TOP = imax(FPA_GAP, FPA_ST_GAP);
  localparam int INT_TOP = imax(INT_BR_GAP, INT_GAP);

  logic [CNTW-1:0] off;

  always_comb begin
    unique case (kind)
      PK_FPADD:  off = (cons == CLS_STORE)  ? CNTW'(FPA_TOP - FPA_ST_GAP)
                                            : CNTW'(FPA_TOP - FPA_GAP);
      PK_INTADD: off = (cons == CLS_BRANCH) ? CNTW'(INT_TOP - INT_BR_GAP)
                                            : CNTW'(INT_TOP - INT_GAP);
      PK_LOAD:   off = CNTW'(FPA_TOP - FPA_TOP);
      default:   off = CNTW'(FPA_TOP - FPA_TOP);
    endcase
  end

  always_comb begin
    if (src_vld && kind != PK_NONE && cnt > off) need = cnt - off;
    else                                         need = '0;
  end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int NREG       = 32,
  parameter int LD_GAP     = 3,
  parameter int FPA_GAP    = 5,
  parameter int FPA_ST_GAP = 4,
  parameter int INT_BR_GAP = 2,
  parameter int INT_GAP    = 1,
  localparam int IDXW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_cls,
  input  logic            in_dst_vld,
  input  logic            in_dst_fp,
  input  logic [IDXW-1:0] in_dst_idx,
  input  logic            in_sa_vld,
  input  logic            in_sa_fp,
  input  logic [IDXW-1:0] in_sa_idx,
  input  logic            in_sb_vld,
  input  logic            in_sb_fp,
  input  logic [IDXW-1:0] in_sb_idx,
  output logic            stall,
  output logic            issue,
  output logic            delay_slot
);

  localparam int FPA_TOP = imax(FPA_GAP, FPA_ST_GAP);
  localparam int INT_TOP = imax(INT_BR_GAP, INT_GAP);
  localparam int MAXGAP  = imax(imax(LD_GAP, FPA_TOP), INT_TOP);
  localparam int CNTW    = $clog2(MAXGAP + 1);

  cls_e cls;
  assign cls = cls_e'(in_cls);

  // producer record written on issue
  logic            wr_en;
  logic [CNTW-1:0] wr_cnt;
  pk_e             wr_kind;

  always_comb begin
    unique case (cls)
      CLS_LOAD:   begin wr_cnt = CNTW'(LD_GAP);  wr_kind = PK_LOAD;   end
      CLS_FPADD:  begin wr_cnt = CNTW'(FPA_TOP); wr_kind = PK_FPADD;  end
      CLS_INTADD: begin wr_cnt = CNTW'(INT_TOP); wr_kind = PK_INTADD; end
      default:    begin wr_cnt = '0;             wr_kind = PK_NONE;   end
    endcase
  end

  assign wr_en = issue && in_dst_vld;

  // per-file scoreboards: index 0 = integer, 1 = floating-point
  logic [CNTW-1:0] rcnt  [2][2];
  pk_e             rkind [2][2];

  for (genvar f = 0; f < 2; f++) begin : g_file
    ilk_sb_file #(
      .NREG(NREG), .CNTW(CNTW), .SKIP_ZERO(f == 0)
    ) u_sb (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en && (in_dst_fp == 1'(f))),
      .wr_idx  (in_dst_idx),
      .wr_cnt  (wr_cnt),
      .wr_kind (wr_kind),
      .rd_idx_a(in_sa_idx),
      .rd_idx_b(in_sb_idx),
      .cnt_a   (rcnt[f][0]),
      .kind_a  (rkind[f][0]),
      .cnt_b   (rcnt[f][1]),
      .kind_b  (rkind[f][1])
    );
  end

  // per-source remaining stall
  logic            src_vld [2];
  logic            src_fp  [2];
  logic [CNTW-1:0] need    [2];

  assign src_vld[0] = in_sa_vld;
  assign src_vld[1] = in_sb_vld;
  assign src_fp[0]  = in_sa_fp;
  assign src_fp[1]  = in_sb_fp;

  for (genvar s = 0; s < 2; s++) begin : g_src
    ilk_src_need #(
      .CNTW(CNTW), .LD_GAP(LD_GAP), .FPA_GAP(FPA_GAP),
      .FPA_ST_GAP(FPA_ST_GAP), .INT_BR_GAP(INT_BR_GAP), .INT_GAP(INT_GAP)
    ) u_need (
      .src_vld(src_vld[s]),
      .cnt    (src_fp[s] ? rcnt[1][s]  : rcnt[0][s]),
      .kind   (src_fp[s] ? rkind[1][s] : rkind[0][s]),
      .cons   (cls),
      .need   (need[s])
    );
  end

  logic [CNTW-1:0] need_max;
  assign need_max = (need[0] > need[1]) ? need[0] : need[1];

  assign in_ready = (need_max == '0) || !in_valid;
  assign issue    = in_valid && in_ready;
  assign stall    = in_valid && !in_ready;

  // delay slot tracking
  logic br_pend_q;

  always_ff @(posedge clk) begin
    if (rst)        br_pend_q <= 1'b0;
    else if (issue) br_pend_q <= (cls == CLS_BRANCH);
  end

  assign delay_slot = issue && br_pend_q;

  logic [23:0] in_pkt;
  assign in_pkt = {in_valid, in_cls, in_dst_vld, in_dst_fp, in_dst_idx,
                   in_sa_vld, in_sa_fp, in_sa_idx, in_sb_vld, in_sb_fp, in_sb_idx};

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (in_ready && !stall && !issue));

  // R7
  stall_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!$stable(in_pkt) || need_max < $past(need_max)));

  // R9
  zero_src_free_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!in_sa_vld || (!in_sa_fp && in_sa_idx == '0))
              && (!in_sb_vld || (!in_sb_fp && in_sb_idx == '0))) |-> issue);

  // R10
  slot_after_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && cls == CLS_BRANCH) |=> (issue |-> delay_slot));

endmodule

// File: tb/test_issue_interlock.sv
module test_issue_interlock;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_ready;
  logic [2:0] in_cls;
  logic       in_dst_vld, in_dst_fp;
  logic [4:0] in_dst_idx;
  logic       in_sa_vld, in_sa_fp;
  logic [4:0] in_sa_idx;
  logic       in_sb_vld, in_sb_fp;
  logic [4:0] in_sb_idx;
  logic       stall, issue, delay_slot;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  issue_interlock i_issue_interlock (
    .clk, .rst, .in_valid, .in_ready, .in_cls,
    .in_dst_vld, .in_dst_fp, .in_dst_idx,
    .in_sa_vld, .in_sa_fp, .in_sa_idx,
    .in_sb_vld, .in_sb_fp, .in_sb_idx,
    .stall, .issue, .delay_slot
  );

  // {cls, dv, dfp, d, s1v, s1fp, s1, s2v, s2fp, s2, exp_stalls, exp_slot}
  // cls: 0 other, 1 load, 2 fpadd, 3 intadd, 4 store, 5 branch
  localparam int NV = 31;
  localparam logic [27:0] VEC [NV] = '{
    {3'd1, 1'b1,1'b1,5'd1,  1'b1,1'b0,5'd1,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // ld f1
    {3'd1, 1'b1,1'b1,5'd2,  1'b1,1'b0,5'd2,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // ld f2
    {3'd2, 1'b1,1'b1,5'd1,  1'b1,1'b1,5'd2,  1'b1,1'b1,5'd1,  3'd3,1'b0}, // R2 fpadd f1
    {3'd4, 1'b0,1'b0,5'd0,  1'b1,1'b1,5'd1,  1'b1,1'b0,5'd1,  3'd4,1'b0}, // R4 store f1
    {3'd3, 1'b1,1'b0,5'd1,  1'b1,1'b0,5'd1,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // int r1
    {3'd3, 1'b1,1'b0,5'd2,  1'b1,1'b0,5'd2,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // int r2
    {3'd5, 1'b0,1'b0,5'd0,  1'b1,1'b0,5'd1,  1'b1,1'b0,5'd3,  3'd1,1'b0}, // R5 R7 br
    {3'd0, 1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  3'd0,1'b1}, // R10 slot
    {3'd2, 1'b1,1'b1,5'd3,  1'b1,1'b1,5'd4,  1'b1,1'b1,5'd5,  3'd0,1'b0}, // fpadd f3
    {3'd0, 1'b0,1'b0,5'd0,  1'b1,1'b1,5'd3,  1'b0,1'b0,5'd0,  3'd5,1'b0}, // R3
    {3'd3, 1'b1,1'b0,5'd5,  1'b1,1'b0,5'd6,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // int r5
    {3'd0, 1'b0,1'b0,5'd0,  1'b1,1'b0,5'd5,  1'b0,1'b0,5'd0,  3'd1,1'b0}, // R6
    {3'd3, 1'b1,1'b0,5'd0,  1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // int r0
    {3'd0, 1'b0,1'b0,5'd0,  1'b1,1'b0,5'd0,  1'b1,1'b0,5'd0,  3'd0,1'b0}, // R9
    {3'd1, 1'b1,1'b1,5'd7,  1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // ld f7
    {3'd0, 1'b0,1'b0,5'd0,  1'b1,1'b0,5'd7,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // R8 int r7
    {3'd0, 1'b0,1'b0,5'd0,  1'b1,1'b1,5'd7,  1'b0,1'b0,5'd0,  3'd2,1'b0}, // R2 R7 f7
    {3'd3, 1'b1,1'b0,5'd8,  1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // int r8
    {3'd5, 1'b0,1'b0,5'd0,  1'b1,1'b0,5'd8,  1'b0,1'b0,5'd0,  3'd2,1'b0}, // R5 br
    {3'd0, 1'b0,1'b0,5'd0,  1'b1,1'b1,5'd9,  1'b0,1'b0,5'd0,  3'd0,1'b1}, // R10 slot
    {3'd2, 1'b1,1'b1,5'd10, 1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // fpadd f10
    {3'd1, 1'b1,1'b1,5'd11, 1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // ld f11
    {3'd0, 1'b0,1'b0,5'd0,  1'b1,1'b1,5'd11, 1'b1,1'b1,5'd10, 3'd4,1'b0}, // R7 max
    {3'd2, 1'b1,1'b1,5'd12, 1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // fpadd f12
    {3'd4, 1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  1'b1,1'b1,5'd12, 3'd4,1'b0}, // R4 store
    {3'd3, 1'b1,1'b0,5'd13, 1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // int r13
    {3'd4, 1'b0,1'b0,5'd0,  1'b1,1'b0,5'd13, 1'b0,1'b0,5'd0,  3'd1,1'b0}, // R6 store
    {3'd3, 1'b1,1'b0,5'd15, 1'b0,1'b0,5'd0,  1'b0,1'b0,5'd0,  3'd0,1'b0}, // int r15
    {3'd5, 1'b0,1'b0,5'd0,  1'b1,1'b0,5'd15, 1'b0,1'b0,5'd0,  3'd2,1'b0}, // R5 br
    {3'd0, 1'b0,1'b0,5'd0,  1'b1,1'b0,5'd15, 1'b0,1'b0,5'd0,  3'd0,1'b1}, // R10 slot
    {3'd0, 1'b0,1'b0,5'd0,  1'b1,1'b0,5'd15, 1'b0,1'b0,5'd0,  3'd0,1'b0}  // R10 no slot
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [27:0] v);
    in_valid   = 1'b1;
    in_cls     = v[27:25];
    in_dst_vld = v[24]; in_dst_fp = v[23]; in_dst_idx = v[22:18];
    in_sa_vld  = v[17]; in_sa_fp  = v[16]; in_sa_idx  = v[15:11];
    in_sb_vld  = v[10]; in_sb_fp  = v[9];  in_sb_idx  = v[8:4];
  endtask

  // called at a negedge; returns at a later negedge after the issue edge
  task automatic send(input logic [27:0] v, output int stalls, output logic slot);
    stalls = 0;
    slot   = 1'b0;
    drive(v);
    forever begin
      #1;
      if (issue) begin
        slot = delay_slot;
        @(negedge clk);
        break;
      end
      stalls++;
      if (stalls > 20) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    int st;
    logic sl;
    rst = 1'b1;
    drive('0);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 R1 state after reset
    check("R11 ready after reset", int'(in_ready), 1);
    check("R1 idle stall", int'(stall), 0);
    check("R1 idle issue", int'(issue), 0);
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k], st, sl);
      check($sformatf("R2-R10 vec %0d stalls", k), st, int'(VEC[k][3:1]));
      check($sformatf("R10 vec %0d slot", k), int'(sl), int'(VEC[k][0]));
    end

    // R1: dependent packet with valid low is not stalled
    send({3'd2, 1'b1,1'b1,5'd20, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 3'd0,1'b0}, st, sl);
    drive({3'd0, 1'b0,1'b0,5'd0, 1'b1,1'b1,5'd20, 1'b0,1'b0,5'd0, 3'd0,1'b0});
    in_valid = 1'b0;
    #1;
    check("R1 no valid no stall", int'(stall), 0);
    check("R1 no valid ready", int'(in_ready), 1);
    @(negedge clk);

    // R11: reset during a stall releases it
    send({3'd2, 1'b1,1'b1,5'd21, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 3'd0,1'b0}, st, sl);
    drive({3'd0, 1'b0,1'b0,5'd0, 1'b1,1'b1,5'd21, 1'b0,1'b0,5'd0, 3'd0,1'b0});
    #1;
    check("R3 stalled before reset", int'(stall), 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R11 stall cleared", int'(stall), 0);
    check("R11 issue after reset", int'(issue), 1);
    @(negedge clk);
    in_valid = 1'b0;

    // R11: reset cancels a pending delay slot
    send({3'd5, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 3'd0,1'b0}, st, sl);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send({3'd0, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 3'd0,1'b0}, st, sl);
    check("R11 slot cleared", int'(sl), 0);
    check("R11 slot stalls", st, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule